// File: doc/BRIEF.md
# Program Flow Trace and Breakpoint Unit

This debug block sits beside a processor's instruction fetch path and data path. On every fetch it compares the new program address with the one fetched before it. When the new address is not the previous one plus one, the program has taken a jump. The block then stores a pair in a small trace queue: the last address before the jump and the jump target. Later, debug software drains the queue and rebuilds the whole execution path from these pairs alone. Fetches that the core marks as dummy are skipped completely.

The same block raises a one-cycle trap request when one of these conditions occurs:
- an enabled program-address comparator matches;
- an enabled data-address comparator matches;
- an enabled data-value comparator matches;
- single stepping is on and a real instruction is fetched.

A cause vector tells which source fired. The trace queue is read through a valid/ready stream. The consumer may hold ready low for as long as it likes. While ready is low, the head entry and the entry order do not change. The one exception is a queue that is full when a new jump arrives: the oldest entry is then dropped and a sticky overflow flag rises.

Top module: `flow_trace_unit`

## Requirements
- R1: After reset, trc_valid, trap, trap_why and trc_overflow are all 0.
- R2: A non-dummy fetch whose address equals the previous non-dummy fetch address plus one, modulo 2^16 (so 0xFFFF to 0x0000 counts as sequential), adds no trace entry. The first non-dummy fetch after reset adds no entry either.
- R3: A non-dummy fetch whose address is not the previous address plus one adds an entry: trc_src is the previous non-dummy fetch address and trc_dst is the new address. The entry is visible on trc_valid, trc_src and trc_dst in the cycle after the fetch is sampled.
- R4: A fetch with fetch_dummy=1 adds no entry, does not become the "previous address" for R2 and R3, and raises no trap.
- R5: trc_valid is 1 exactly while the queue holds an entry. An entry is removed on a clock edge where trc_valid and trc_ready are both 1. Entries come out oldest first. While trc_ready is 0 and no overwrite occurs, trc_valid stays 1 and the head entry is unchanged.
- R6: If a new entry arrives while the queue holds DEPTH entries and no entry is removed in that cycle, the oldest entry is discarded and trc_overflow goes to 1. trc_overflow then stays 1 until reset.
- R7: With pbp_en=1, a non-dummy fetch of address pbp_addr makes trap 1 for exactly one cycle, in the cycle after the fetch. During that cycle trap_why bit 0 is 1. Whenever trap is 0, trap_why is 0.
- R8: With dabp_en=1, a cycle with dat_valid=1 and dat_addr=dabp_addr makes trap pulse in the next cycle with trap_why bit 1 set.
- R9: With dvbp_en=1, a cycle with dat_valid=1 and dat_value=dvbp_value makes trap pulse in the next cycle with trap_why bit 2 set.
- R10: With step_en=1, every non-dummy fetch makes trap pulse in the next cycle with trap_why bit 3 set.
- R11: A comparator whose enable is 0 never causes a trap, even when its operand matches. A cycle with neither fetch_valid nor dat_valid is followed by trap=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A program fetch occurs this cycle |
| fetch_dummy | input | 1 | The current fetch is a dummy fetch |
| fetch_addr | input | 16 | Program address of the fetch |
| dat_valid | input | 1 | A data access occurs this cycle |
| dat_addr | input | 16 | Data address |
| dat_value | input | 16 | Data bus value |
| pbp_en | input | 1 | Enable for the program-address comparator |
| pbp_addr | input | 16 | Program address to match |
| dabp_en | input | 1 | Enable for the data-address comparator |
| dabp_addr | input | 16 | Data address to match |
| dvbp_en | input | 1 | Enable for the data-value comparator |
| dvbp_value | input | 16 | Data value to match |
| step_en | input | 1 | Single-step: trap after every real fetch |
| trap | output | 1 | One-cycle halt request |
| trap_why | output | 4 | Trap causes: bit0 program address, bit1 data address, bit2 data value, bit3 step |
| trc_valid | output | 1 | The trace stream holds an entry |
| trc_ready | input | 1 | Consumer accepts the head entry |
| trc_src | output | 16 | Head entry: last address before the jump |
| trc_dst | output | 16 | Head entry: jump target |
| trc_overflow | output | 1 | Sticky: an entry was lost because the queue was full |

## Verification
A corrupted "previous address" register shows up on the very next real fetch. Either a spurious entry appears or an expected one is missing, or trc_src differs from the true last address one cycle after the fetch. Faulty queue pointers or a faulty count show up at the stream head: wrong order after a back-pressure hold, wrong survivors after an overwrite, or a wrong number of drained entries. Comparator faults show up as a missing, stretched or mislabelled trap pulse in the cycle right after the match.

// File: rtl/ftu_pkg.sv
package ftu_pkg;
  localparam int NCAUSE    = 4;
  localparam int CAUSE_PA  = 0;
  localparam int CAUSE_DA  = 1;
  localparam int CAUSE_DV  = 2;
  localparam int CAUSE_STP = 3;
  localparam int NCMP      = 3;
endpackage

// File: rtl/ftu_discont.sv
module ftu_discont #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic          fetch_dummy,
  input  logic [AW-1:0] fetch_addr,
  output logic          push,
  output logic [AW-1:0] push_src,
  output logic [AW-1:0] push_dst
);
  logic [AW-1:0] prev_addr;
  logic          prev_ok;
  logic          real_fetch;

  assign real_fetch = fetch_valid && !fetch_dummy;
  assign push       = real_fetch && prev_ok && (fetch_addr != prev_addr + AW'(1));
  assign push_src   = prev_addr;
  assign push_dst   = fetch_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_ok   <= 1'b0;
    end else if (real_fetch) begin
      prev_addr <= fetch_addr;
      prev_ok   <= 1'b1;
    end
  end
endmodule

// File: rtl/ftu_trace_fifo.sv
module ftu_trace_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW:0]   FULL = (PW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   count;
  logic          full, pop, drop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  assign full      = (count == FULL);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = out_valid && out_ready;
  assign drop      = push && full && !pop;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop || drop) rd_ptr <= bump(rd_ptr);
      if (push && !pop && !full) count <= count + 1'b1;
      else if (pop && !push)     count <= count - 1'b1;
      if (drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/ftu_bp_match.sv
module ftu_bp_match
  import ftu_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              fetch_dummy,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              dat_valid,
  input  logic [AW-1:0]     dat_addr,
  input  logic [DW-1:0]     dat_value,
  input  logic              pbp_en,
  input  logic [AW-1:0]     pbp_addr,
  input  logic              dabp_en,
  input  logic [AW-1:0]     dabp_addr,
  input  logic              dvbp_en,
  input  logic [DW-1:0]     dvbp_value,
  input  logic              step_en,
  output logic              trap,
  output logic [NCAUSE-1:0] trap_why
);
  localparam int CW = (AW > DW) ? AW : DW;

  logic [CW-1:0]     opnd [NCMP];
  logic [CW-1:0]     refv [NCMP];
  logic [NCMP-1:0]   en, qual, cmp_hit;
  logic [NCAUSE-1:0] hit;
  logic              real_fetch;

  assign real_fetch = fetch_valid && !fetch_dummy;

  always_comb begin
    opnd[CAUSE_PA] = CW'(fetch_addr); refv[CAUSE_PA] = CW'(pbp_addr);
    en[CAUSE_PA]   = pbp_en;          qual[CAUSE_PA] = real_fetch;
    opnd[CAUSE_DA] = CW'(dat_addr);   refv[CAUSE_DA] = CW'(dabp_addr);
    en[CAUSE_DA]   = dabp_en;         qual[CAUSE_DA] = dat_valid;
    opnd[CAUSE_DV] = CW'(dat_value);  refv[CAUSE_DV] = CW'(dvbp_value);
    en[CAUSE_DV]   = dvbp_en;         qual[CAUSE_DV] = dat_valid;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign cmp_hit[i] = en[i] && qual[i] && (opnd[i] == refv[i]);
  end

  assign hit = {step_en && real_fetch, cmp_hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap     <= 1'b0;
      trap_why <= '0;
    end else begin
      trap     <= |hit;
      trap_why <= hit;
    end
  end
endmodule

// File: rtl/flow_trace_unit.sv
module flow_trace_unit
  import ftu_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic              fetch_dummy,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              dat_valid,
  input  logic [AW-1:0]     dat_addr,
  input  logic [DW-1:0]     dat_value,
  input  logic              pbp_en,
  input  logic [AW-1:0]     pbp_addr,
  input  logic              dabp_en,
  input  logic [AW-1:0]     dabp_addr,
  input  logic              dvbp_en,
  input  logic [DW-1:0]     dvbp_value,
  input  logic              step_en,
  output logic              trap,
  output logic [NCAUSE-1:0] trap_why,
  output logic              trc_valid,
  input  logic              trc_ready,
  output logic [AW-1:0]     trc_src,
  output logic [AW-1:0]     trc_dst,
  output logic              trc_overflow
);
  localparam int EW = 2 * AW;

  logic          push;
  logic [AW-1:0] push_src, push_dst;
  logic [EW-1:0] head;

  ftu_discont #(.AW(AW)) u_disc (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .fetch_dummy(fetch_dummy), .fetch_addr(fetch_addr),
    .push(push), .push_src(push_src), .push_dst(push_dst)
  );

  ftu_trace_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data({push_src, push_dst}),
    .out_valid(trc_valid), .out_ready(trc_ready), .out_data(head),
    .overflow(trc_overflow)
  );

  assign trc_src = head[EW-1:AW];
  assign trc_dst = head[AW-1:0];

  ftu_bp_match #(.AW(AW), .DW(DW)) u_bp (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .fetch_dummy(fetch_dummy), .fetch_addr(fetch_addr),
    .dat_valid(dat_valid), .dat_addr(dat_addr), .dat_value(dat_value),
    .pbp_en(pbp_en), .pbp_addr(pbp_addr), .dabp_en(dabp_en),
    .dabp_addr(dabp_addr), .dvbp_en(dvbp_en), .dvbp_value(dvbp_value),
    .step_en(step_en), .trap(trap), .trap_why(trap_why)
  );
endmodule

// File: rtl/ftu_checker.sv
module ftu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_valid,
  input logic       fetch_dummy,
  input logic       dat_valid,
  input logic       trap,
  input logic [3:0] trap_why,
  input logic       trc_valid,
  input logic       trc_ready,
  input logic       trc_overflow
);
  // R7: a trap always names a cause
  p_why_on_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (trap_why != 4'b0));
  // R7: no cause without a trap
  p_why_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> (trap_why == 4'b0));
  // R4: a lone dummy fetch raises no trap
  p_dummy_no_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_dummy && !dat_valid) |=> !trap);
  // R11: an idle cycle raises no trap
  p_idle_no_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !dat_valid) |=> !trap);
  // R6: the overflow flag is sticky
  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trc_overflow |=> trc_overflow);
  // R5: a held entry stays offered
  p_valid_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && !trc_ready) |=> trc_valid);
endmodule

bind flow_trace_unit ftu_checker u_ftu_checker (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_dummy(fetch_dummy),
  .dat_valid(dat_valid), .trap(trap), .trap_why(trap_why), .trc_valid(trc_valid),
  .trc_ready(trc_ready), .trc_overflow(trc_overflow)
);

// File: tb/flow_trace_unit_test.sv
`timescale 1ns/1ps
module flow_trace_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 0, fetch_dummy = 0;
  logic [15:0] fetch_addr = '0;
  logic        dat_valid = 0;
  logic [15:0] dat_addr = '0, dat_value = '0;
  logic        pbp_en = 0, dabp_en = 0, dvbp_en = 0, step_en = 0;
  logic [15:0] pbp_addr = '0, dabp_addr = '0, dvbp_value = '0;
  logic        trap, trc_valid, trc_overflow;
  logic        trc_ready = 0;
  logic [3:0]  trap_why;
  logic [15:0] trc_src, trc_dst;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flow_trace_unit #(.DEPTH(4)) uut (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [15:0] a, input logic dmy);
    fetch_valid = 1; fetch_dummy = dmy; fetch_addr = a;
    tick();
    fetch_valid = 0; fetch_dummy = 0;
  endtask

  task automatic do_data(input logic [15:0] a, input logic [15:0] v);
    dat_valid = 1; dat_addr = a; dat_value = v;
    tick();
    dat_valid = 0;
  endtask

  task automatic drain(output int n);
    n = 0;
    trc_ready = 1;
    while (trc_valid && n < 32) begin tick(); n++; end
    trc_ready = 0;
  endtask

  task automatic pop_expect(input string tag, input logic [15:0] s, input logic [15:0] d);
    chk({tag, " valid"}, 32'(trc_valid), 32'd1);
    chk({tag, " src"}, 32'(trc_src), 32'(s));
    chk({tag, " dst"}, 32'(trc_dst), 32'(d));
    trc_ready = 1; tick(); trc_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1 trc_valid", 32'(trc_valid), 0);
    chk("R1 trap", 32'(trap), 0);
    chk("R1 trap_why", 32'(trap_why), 0);
    chk("R1 overflow", 32'(trc_overflow), 0);
  endtask

  task automatic t_sequential();
    int n;
    do_fetch(16'h0100, 0);
    chk("R2 first fetch no entry", 32'(trc_valid), 0);
    do_fetch(16'h0101, 0);
    do_fetch(16'h0102, 0);
    chk("R2 sequential no entry", 32'(trc_valid), 0);
    do_fetch(16'hFFFF, 0); drain(n);
    do_fetch(16'h0000, 0);
    chk("R2 wrap is sequential", 32'(trc_valid), 0);
  endtask

  task automatic t_jump();
    int n;
    do_fetch(16'h0010, 0); drain(n);
    do_fetch(16'h0050, 0);
    pop_expect("R3 jump", 16'h0010, 16'h0050);
    chk("R5 empty after pop", 32'(trc_valid), 0);
  endtask

  task automatic t_dummy();
    int n;
    do_fetch(16'h0060, 0); drain(n);
    do_fetch(16'h0900, 1);
    chk("R4 dummy no trap", 32'(trap), 0);
    chk("R4 dummy no entry", 32'(trc_valid), 0);
    do_fetch(16'h0061, 0);
    chk("R4 dummy not previous", 32'(trc_valid), 0);
  endtask

  task automatic t_order();
    int n;
    do_fetch(16'h0700, 0); drain(n);
    do_fetch(16'h0800, 0);
    do_fetch(16'h0900, 0);
    do_fetch(16'h0A00, 0);
    repeat (3) tick();
    chk("R5 held valid", 32'(trc_valid), 1);
    pop_expect("R5 order 1", 16'h0700, 16'h0800);
    pop_expect("R5 order 2", 16'h0800, 16'h0900);
    pop_expect("R5 order 3", 16'h0900, 16'h0A00);
    chk("R5 drained", 32'(trc_valid), 0);
  endtask

  task automatic t_overflow();
    int n;
    do_fetch(16'h1000, 0); drain(n);
    chk("R6 no overflow yet", 32'(trc_overflow), 0);
    do_fetch(16'h2000, 0);
    do_fetch(16'h3000, 0);
    do_fetch(16'h4000, 0);
    do_fetch(16'h5000, 0);
    chk("R6 full no overflow", 32'(trc_overflow), 0);
    do_fetch(16'h6000, 0);
    chk("R6 overflow set", 32'(trc_overflow), 1);
    chk("R6 oldest dropped src", 32'(trc_src), 32'h2000);
    chk("R6 oldest dropped dst", 32'(trc_dst), 32'h3000);
    drain(n);
    chk("R6 survivors", 32'(n), 4);
    tick();
    chk("R6 overflow sticky", 32'(trc_overflow), 1);
  endtask

  task automatic t_breakpoints();
    int n;
    pbp_addr = 16'h0C00; pbp_en = 0;
    do_fetch(16'h0C00, 0);
    chk("R11 disabled pa", 32'(trap), 0);
    pbp_en = 1;
    do_fetch(16'h0C00, 0);
    chk("R7 pa trap", 32'(trap), 1);
    chk("R7 pa why", 32'(trap_why), 32'h1);
    tick();
    chk("R7 one cycle", 32'(trap), 0);
    do_fetch(16'h0C00, 1);
    chk("R7 dummy no pa trap", 32'(trap), 0);
    pbp_en = 0;

    dabp_addr = 16'h4444; dvbp_value = 16'hBEEF;
    do_data(16'h4444, 16'hBEEF);
    chk("R11 disabled data", 32'(trap), 0);
    dabp_en = 1;
    do_data(16'h4444, 16'h0001);
    chk("R8 da trap", 32'(trap), 1);
    chk("R8 da why", 32'(trap_why), 32'h2);
    dabp_en = 0; dvbp_en = 1;
    do_data(16'h0002, 16'hBEEF);
    chk("R9 dv trap", 32'(trap), 1);
    chk("R9 dv why", 32'(trap_why), 32'h4);
    do_data(16'h0002, 16'hBEEE);
    chk("R9 dv mismatch", 32'(trap), 0);
    dvbp_en = 0;

    step_en = 1;
    do_fetch(16'h0B00, 0);
    chk("R10 step trap", 32'(trap), 1);
    chk("R10 step why", 32'(trap_why), 32'h8);
    do_fetch(16'h0B01, 0);
    chk("R10 step again", 32'(trap), 1);
    do_fetch(16'h0B02, 1);
    chk("R10 dummy no step", 32'(trap), 0);
    step_en = 0;
    do_fetch(16'h0B02, 0);
    chk("R11 step off", 32'(trap), 0);
    drain(n);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_sequential();
    t_jump();
    t_dummy();
    t_order();
    t_overflow();
    t_breakpoints();
    finish_run();
  end
endmodule